// File: doc/BRIEF.md
# Pointer-Indirect Data RAM Unit

This unit carries out the indirect load and store operations of a small 8-bit microcontroller core. The core hands it one 16-bit instruction word, the current value of the single pointer register (R30), and, for stores, the source register byte. The unit decodes the word and forms the effective address. It reads or writes its own 128-byte RAM and returns the loaded byte together with the destination register index. It also supplies the new pointer value for the auto-modify forms.

The RAM covers data addresses 0x60 through 0xDF and nothing else lives in the data space. An address outside that window reads as zero, and a store to it is dropped. Only the pointer register can address the RAM, so any other addressing form is not an access. Every access completes in the cycle it is accepted. A store lands on that cycle's rising edge, and load data and the new pointer value are presented combinationally in the same cycle.

The instruction side uses a valid/ready pair, and so does the load write-back side. The unit does not buffer anything. When the write-back consumer holds `wb_ready` low, `op_ready` is low as well. An offered instruction then has no effect and must stay offered until it is taken.

Top module: `zram_unit`

## Requirements
- R1: Only six encodings are accesses: 1000 000d dddd 0000 (load, plain), 1001 000d dddd 0001 (load, post-increment), 1001 000d dddd 0010 (load, pre-decrement), and the same three with bit 9 set (stores). Any other word gives no RAM strobe, no pointer update and no `wb_valid`. This includes the forms that name other pointers (low nibble 1100, 1101, 1110, 1000, 1001, 1010) and the direct form 1001 000d dddd 0000. `ram_rd` and `ram_wr` are never high together.
- R2: The plain form accesses the address equal to the pointer and leaves the pointer unchanged (`z_wr` low).
- R3: The post-increment form accesses the address equal to the pointer, raises `z_wr` and drives `z_new` = pointer + 1 modulo 256 (0xFF becomes 0x00).
- R4: The pre-decrement form accesses pointer − 1 modulo 256, raises `z_wr` and drives `z_new` to that same value (0x00 becomes 0xFF).
- R5: RAM word index = effective address − 0x60. For an effective address below 0x60 or above 0xDF, a load returns 0x00 with `ram_rd` low, and a store leaves every RAM byte unchanged with `ram_wr` low.
- R6: An accepted store writes the RAM on the rising edge that ends its cycle. A load presents the stored byte on `wb_data` in the same cycle it is offered, with `wb_reg` = bits 7:4 of the word (register 16 + index).
- R7: `op_ready` follows `wb_ready`. While `op_valid` is high and `op_ready` is low, nothing is written and `z_wr`, `ram_rd`, `ram_wr` stay low. `wb_valid` is high whenever a load encoding is offered.
- R8: A register field below 16 (bit 8 clear) is not an access and is handled as in R1.
- R9: After reset, every RAM byte reads 0x00 and all strobes are low while no operation is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Instruction word offered |
| op_ready | output | 1 | Instruction accepted this cycle when high with `op_valid` |
| op_word | input | 16 | Instruction word |
| z_in | input | 8 | Current pointer register value |
| st_data | input | 8 | Source register byte for stores |
| wb_valid | output | 1 | Load result offered |
| wb_ready | input | 1 | Write-back consumer can take a result |
| wb_reg | output | 4 | Destination register index minus 16 |
| wb_data | output | 8 | Loaded byte |
| z_wr | output | 1 | Pointer write-back enable |
| z_new | output | 8 | New pointer value |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |

## Verification
Assertions check on every cycle the things that hold at any single instant. The two strobes never overlap. A strobe fires only inside the window. An out-of-window load returns zero. The pointer step matches the addressing mode, and a stalled offer stays inert. Whether a store really landed in the right byte, and did not alias into another, can only be seen from the scenarios. These store and then load back across the window edges. They also check the pointer wrap cases, the rejected encodings and stalled stores.

// File: rtl/zram_pkg.sv
package zram_pkg;
  typedef enum logic [1:0] {
    AM_PLAIN = 2'd0,
    AM_POST  = 2'd1,
    AM_PRE   = 2'd2
  } amode_e;

  typedef struct packed {
    logic       hit;
    logic       store;
    amode_e     mode;
    logic [3:0] reg_idx;
  } zop_t;
endpackage

// File: rtl/zram_decode.sv
module zram_decode
  import zram_pkg::*;
(
  input  logic [15:0] word,
  output zop_t        op
);
  logic frame_ok;

  // Group bits, register bank bit (upper 16 only)
  assign frame_ok = (word[15:13] == 3'b100) && (word[11:10] == 2'b00) && word[8];

  always_comb begin
    op         = '0;
    op.mode    = AM_PLAIN;
    op.store   = word[9];
    op.reg_idx = word[7:4];
    if (frame_ok) begin
      if (!word[12] && word[3:0] == 4'h0) begin
        op.hit  = 1'b1;
        op.mode = AM_PLAIN;
      end else if (word[12] && word[3:0] == 4'h1) begin
        op.hit  = 1'b1;
        op.mode = AM_POST;
      end else if (word[12] && word[3:0] == 4'h2) begin
        op.hit  = 1'b1;
        op.mode = AM_PRE;
      end
    end
  end
endmodule

// File: rtl/zram_agu.sv
module zram_agu
  import zram_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned RAM_BASE  = 'h60,
  parameter int unsigned RAM_DEPTH = 128,
  parameter int unsigned AW        = $clog2(RAM_DEPTH)
) (
  input  logic [DW-1:0] z,
  input  amode_e        mode,
  output logic [DW-1:0] z_next,
  output logic          in_win,
  output logic [AW-1:0] idx
);
  localparam logic [DW:0]   WIN_LO = (DW+1)'(RAM_BASE);
  localparam logic [DW:0]   WIN_HI = (DW+1)'(RAM_BASE + RAM_DEPTH);
  localparam logic [DW-1:0] ONE    = DW'(1);

  logic [DW-1:0] dec, inc, ea;
  logic [DW:0]   ea_x;
  logic [DW-1:0] off;

  assign dec  = z - ONE;
  assign inc  = z + ONE;
  assign ea   = (mode == AM_PRE) ? dec : z;
  assign ea_x = {1'b0, ea};

  always_comb begin
    case (mode)
      AM_PRE:  z_next = dec;
      AM_POST: z_next = inc;
      default: z_next = z;
    endcase
  end

  assign in_win = (ea_x >= WIN_LO) && (ea_x < WIN_HI);
  assign off    = ea - DW'(RAM_BASE);
  assign idx    = off[AW-1:0];
endmodule

// File: rtl/zram_store.sv
module zram_store #(
  parameter int unsigned DW        = 8,
  parameter int unsigned RAM_DEPTH = 128,
  parameter int unsigned AW        = $clog2(RAM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [RAM_DEPTH];

  for (genvar g = 0; g < RAM_DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mem[g] <= '0;
      else if (we && idx == AW'(g))      mem[g] <= wdata;
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/zram_unit.sv
module zram_unit
  import zram_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned RAM_BASE  = 'h60,
  parameter int unsigned RAM_DEPTH = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [15:0]   op_word,
  input  logic [DW-1:0] z_in,
  input  logic [DW-1:0] st_data,
  output logic          wb_valid,
  input  logic          wb_ready,
  output logic [3:0]    wb_reg,
  output logic [DW-1:0] wb_data,
  output logic          z_wr,
  output logic [DW-1:0] z_new,
  output logic          ram_rd,
  output logic          ram_wr
);
  localparam int unsigned AW = $clog2(RAM_DEPTH);

  zop_t          dop;
  logic          in_win, fire, mode_post, mode_pre;
  logic [AW-1:0] idx;
  logic [DW-1:0] rdata;

  zram_decode u_dec (.word(op_word), .op(dop));

  zram_agu #(.DW(DW), .RAM_BASE(RAM_BASE), .RAM_DEPTH(RAM_DEPTH), .AW(AW)) u_agu (
    .z(z_in), .mode(dop.mode), .z_next(z_new), .in_win(in_win), .idx(idx)
  );

  zram_store #(.DW(DW), .RAM_DEPTH(RAM_DEPTH), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(ram_wr), .idx(idx), .wdata(st_data), .rdata(rdata)
  );

  assign mode_post = dop.hit && (dop.mode == AM_POST);
  assign mode_pre  = dop.hit && (dop.mode == AM_PRE);

  assign op_ready = wb_ready;
  assign fire     = op_valid && op_ready && dop.hit;
  assign wb_valid = op_valid && dop.hit && !dop.store;
  assign wb_reg   = dop.reg_idx;
  assign wb_data  = in_win ? rdata : '0;
  assign ram_rd   = fire && !dop.store && in_win;
  assign ram_wr   = fire && dop.store && in_win;
  assign z_wr     = fire && (dop.mode != AM_PLAIN);
endmodule

// File: rtl/zram_unit_chk.sv
module zram_unit_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic          op_ready,
  input logic          wb_valid,
  input logic [DW-1:0] wb_data,
  input logic          ram_rd,
  input logic          ram_wr,
  input logic          z_wr,
  input logic [DW-1:0] z_in,
  input logic [DW-1:0] z_new,
  input logic          in_win,
  input logic          mode_post,
  input logic          mode_pre
);
  // R1
  rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_rd && ram_wr));

  // R3
  post_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (z_wr && mode_post) |-> z_new == DW'(z_in + DW'(1)));

  // R4
  pre_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (z_wr && mode_pre) |-> z_new == DW'(z_in - DW'(1)));

  // R2
  plain_keeps_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
    z_wr |-> (mode_post || mode_pre));

  // R5
  oow_load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !in_win) |-> wb_data == '0);

  // R5
  strobe_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd || ram_wr) |-> in_win);

  // R7
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |-> (!ram_wr && !ram_rd && !z_wr));
endmodule

bind zram_unit zram_unit_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .wb_valid(wb_valid), .wb_data(wb_data), .ram_rd(ram_rd), .ram_wr(ram_wr),
  .z_wr(z_wr), .z_in(z_in), .z_new(z_new), .in_win(in_win),
  .mode_post(mode_post), .mode_pre(mode_pre)
);

// File: tb/zram_unit_tb_top.sv
module zram_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [15:0] op_word = '0;
  logic [7:0]  z_in = '0;
  logic [7:0]  st_data = '0;
  logic        wb_valid;
  logic        wb_ready = 1'b1;
  logic [3:0]  wb_reg;
  logic [7:0]  wb_data;
  logic        z_wr;
  logic [7:0]  z_new;
  logic        ram_rd;
  logic        ram_wr;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  zram_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_word(op_word), .z_in(z_in), .st_data(st_data), .wb_valid(wb_valid),
    .wb_ready(wb_ready), .wb_reg(wb_reg), .wb_data(wb_data), .z_wr(z_wr),
    .z_new(z_new), .ram_rd(ram_rd), .ram_wr(ram_wr)
  );

  task automatic chk(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // mode: 0 plain, 1 post-increment, 2 pre-decrement
  function automatic logic [15:0] enc(input bit st, input int mode, input int r);
    logic [15:0] w;
    w = 16'h8000;
    if (mode != 0) w = w | 16'h1000;
    if (st)        w = w | 16'h0200;
    w = w | 16'((r & 31) << 4);
    w = w | 16'(mode);
    return w;
  endfunction

  // offer one word, settle, leave it applied until the caller ends the cycle
  task automatic offer(input logic [15:0] w, input logic [7:0] z, input logic [7:0] d);
    @(negedge clk);
    op_valid = 1'b1; op_word = w; z_in = z; st_data = d;
    #1;
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic store(input int mode, input logic [7:0] z, input logic [7:0] d);
    offer(enc(1, mode, 18), z, d);
    idle();
  endtask

  task automatic load_chk(input string req, input logic [7:0] z, input int exp);
    offer(enc(0, 0, 21), z, 8'h00);
    chk(req, wb_data, exp);
    idle();
  endtask

  task automatic t_reset();
    #1;
    chk("R9 ram_wr idle", ram_wr, 0);
    chk("R9 ram_rd idle", ram_rd, 0);
    chk("R9 z_wr idle", z_wr, 0);
    chk("R9 wb_valid idle", wb_valid, 0);
    load_chk("R9 cleared 0x60", 8'h60, 0);
    load_chk("R9 cleared 0xDF", 8'hDF, 0);
  endtask

  task automatic t_plain();
    offer(enc(1, 0, 17), 8'h70, 8'hA5);
    chk("R2 store wr", ram_wr, 1);
    chk("R2 store z_wr", z_wr, 0);
    chk("R6 store no wb_valid", wb_valid, 0);
    idle();
    offer(enc(0, 0, 20), 8'h70, 8'h00);
    chk("R6 load data", wb_data, 8'hA5);
    chk("R6 wb_reg", wb_reg, 4);
    chk("R6 wb_valid", wb_valid, 1);
    chk("R2 load rd", ram_rd, 1);
    chk("R2 load z_wr", z_wr, 0);
    idle();
  endtask

  task automatic t_post();
    for (int i = 0; i < 3; i++) begin
      offer(enc(1, 1, 30), 8'(8'h80 + i), 8'(8'h10 + i));
      chk("R3 z_wr", z_wr, 1);
      chk("R3 z_new", z_new, 8'h81 + i);
      idle();
    end
    for (int i = 0; i < 3; i++) begin
      offer(enc(0, 1, 31), 8'(8'h80 + i), 8'h00);
      chk("R3 load at current z", wb_data, 8'h10 + i);
      chk("R3 wb_reg 15", wb_reg, 15);
      idle();
    end
    offer(enc(0, 1, 16), 8'hFF, 8'h00);
    chk("R3 wrap z_new", z_new, 8'h00);
    chk("R3 wrap oow data", wb_data, 0);
    idle();
  endtask

  task automatic t_pre();
    offer(enc(1, 2, 19), 8'h91, 8'h5C);
    chk("R4 z_new", z_new, 8'h90);
    chk("R4 z_wr", z_wr, 1);
    idle();
    load_chk("R4 wrote z-1", 8'h90, 8'h5C);
    load_chk("R4 not at z", 8'h91, 8'h00);
    offer(enc(0, 2, 16), 8'h00, 8'h00);
    chk("R4 wrap z_new", z_new, 8'hFF);
    chk("R4 wrap rd low", ram_rd, 0);
    idle();
  endtask

  task automatic t_window();
    store(0, 8'h60, 8'h21);
    store(0, 8'hDF, 8'h33);
    offer(enc(1, 0, 17), 8'h5F, 8'h77);
    chk("R5 below window wr", ram_wr, 0);
    idle();
    offer(enc(1, 0, 17), 8'hE0, 8'h88);
    chk("R5 above window wr", ram_wr, 0);
    idle();
    offer(enc(1, 2, 17), 8'h60, 8'h99);
    chk("R5 pre-dec to 0x5F wr", ram_wr, 0);
    idle();
    load_chk("R5 0xDF kept", 8'hDF, 8'h33);
    load_chk("R5 0x60 kept", 8'h60, 8'h21);
    offer(enc(0, 0, 17), 8'hE0, 8'h00);
    chk("R5 oow load data", wb_data, 0);
    chk("R5 oow load rd", ram_rd, 0);
    idle();
  endtask

  task automatic t_reject();
    logic [15:0] bad [6] = '{16'h932C, 16'h932D, 16'h932E, 16'h8228, 16'h9329, 16'h9320};
    foreach (bad[i]) begin
      offer(bad[i], 8'h70, 8'hEE);
      chk("R1 other form wr", ram_wr, 0);
      chk("R1 other form z_wr", z_wr, 0);
      idle();
    end
    offer(16'h900C, 8'h70, 8'h00);
    chk("R1 other pointer load wb_valid", wb_valid, 0);
    idle();
    offer(16'h8210, 8'h70, 8'hEE);
    chk("R8 low register wr", ram_wr, 0);
    idle();
    offer(16'h8010, 8'h70, 8'h00);
    chk("R8 low register wb_valid", wb_valid, 0);
    idle();
    load_chk("R1 R8 byte untouched", 8'h70, 8'hA5);
  endtask

  task automatic t_stall();
    @(negedge clk);
    wb_ready = 1'b0;
    offer(enc(1, 1, 17), 8'h70, 8'h11);
    chk("R7 op_ready low", op_ready, 0);
    chk("R7 stalled wr", ram_wr, 0);
    chk("R7 stalled z_wr", z_wr, 0);
    idle();
    offer(enc(0, 0, 17), 8'h70, 8'h00);
    chk("R7 wb_valid while stalled", wb_valid, 1);
    chk("R7 stalled rd", ram_rd, 0);
    idle();
    wb_ready = 1'b1;
    load_chk("R7 stalled store dropped", 8'h70, 8'hA5);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_post();
    t_pre();
    t_window();
    t_reject();
    t_stall();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule